// File: doc/BRIEF.md
# Link PHY Test Pattern Generator

This block sits between the link encoder and the serializers of a four-lane serial display transmitter and produces one 10-bit symbol per lane per symbol clock. In normal operation the encoded link data passes straight through a single register stage. When the bypass control is raised, the lanes instead carry test content. Each lane picks one of two sources: a pseudo-random bit sequence shared by every lane, or a small loop of eight programmable 10-bit symbols.

The pseudo-random source offers a short polynomial (period 127 bits) and a long polynomial (period 2^23-1 bits). It is reseeded to all ones whenever its enable is low. The symbol loop can be written one slot at a time. It can also be loaded in one step from an 80-bit custom pattern given as ten bytes, which are unpacked into the eight slots. Loading every slot with 0x2AA gives the alternating clock-like pattern used for jitter and eye measurements.

Software sets up the block in a fixed order. It first drops bypass, then sets the lane selects, the polynomial, the enable and the symbols, and finally raises bypass. The symbol loop always restarts from its first slot when bypass rises.

Top module: `phy_tpg_top`

## Requirements
- R1: With `cfg_bypass` low at a clock edge, `lane_out` after that edge equals `link_data_in` sampled at the same edge (one register of latency), for every lane.
- R2: With `cfg_bypass` high, a lane with its select bit at 1 outputs slot 0 in the first cycle after bypass rises, then slots 1, 2, ... 7, and then wraps back to slot 0. Every low-to-high transition of bypass restarts the loop at slot 0.
- R3: When `sym_wr_en` is high at an edge, `sym_wr_data` is stored in the slot numbered `sym_wr_idx`. The other slots keep their values.
- R4: When `cust_load` is high at an edge, the ten bytes b0..b9 (b_k = `cust_bytes[8k+7:8k]`) are stored as: slot0={b1[1:0],b0}, slot1={b2[3:0],b1[7:2]}, slot2={b3[5:0],b2[7:4]}, slot3={b4,b3[7:6]}, and slots 4 to 7 are packed the same way from b5..b9. The custom load takes priority over a single-slot write in the same cycle.
- R5: `cfg_prbs_sel`=0 selects x^7+x^6+1. The state is a shift register; each new bit is state[6]^state[5] and shifts in at bit 0. Each symbol carries ten new bits, the first in symbol bit 0. Starting from the all-ones seed, the first symbol is 0x040, and the lane stream repeats every 127 symbols.
- R6: `cfg_prbs_sel`=1 selects x^23+x^18+1, built the same way with the new bit equal to state[22]^state[17].
- R7: In bypass, a select bit of 1 in `cfg_lane_dbg[l]` sends the symbol loop on lane l, and 0 sends the pseudo-random symbol. All pseudo-random lanes carry the same symbol in the same cycle, and all loop lanes carry the same slot.
- R8: While `cfg_prbs_en` is low, pseudo-random lanes in bypass output 0 and the generator is held at the all-ones seed. The first symbol after it is enabled again is the seed's first symbol.
- R9: After reset, `lane_out` is 0 and every slot holds 0.
- R10: With all eight slots at 0x2AA, every loop lane outputs 0x2AA in every bypass cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bypass | input | 1 | 1 = lanes carry test content, 0 = pass link data |
| cfg_prbs_en | input | 1 | Runs the pseudo-random generator |
| cfg_prbs_sel | input | 1 | Polynomial: 0 short, 1 long |
| cfg_lane_dbg | input | LANES | Per-lane source: 1 symbol loop, 0 pseudo-random |
| sym_wr_en | input | 1 | Write one slot |
| sym_wr_idx | input | log2(SLOTS) | Slot number for the write |
| sym_wr_data | input | SYM_W | Symbol value for the write |
| cust_load | input | 1 | Load all slots from the custom pattern |
| cust_bytes | input | SYM_W*SLOTS | Ten custom bytes, byte 0 in the low bits |
| link_data_in | input | LANES*SYM_W | Encoded link symbols, lane 0 in the low bits |
| lane_out | output | LANES*SYM_W | Registered lane symbols, lane 0 in the low bits |

## Verification
The hardest situation to reach from the ports is the wrap and reseed of the pseudo-random source. Proving the short polynomial's period takes an unbroken run of more than 127 enabled symbols, and the reseed needs the enable to drop and come back while bypass stays high. The bench holds bypass and the enable steady for 300 cycles, records lane 0 and compares the run against itself shifted by 127 symbols. It then toggles the enable once and expects the hand-derived first symbol 0x040 again. The custom unpacking is swept with a single one-bit walking across all 80 pattern bits, and each load is read back through a full loop of the eight slots.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  localparam int PRBS_STATE_W = 23;

  typedef enum logic {
    POLY_SHORT = 1'b0,
    POLY_LONG  = 1'b1
  } poly_e;

  function automatic logic prbs_feedback(input logic [PRBS_STATE_W-1:0] st,
                                         input poly_e poly);
    if (poly == POLY_SHORT) return st[6] ^ st[5];
    else                    return st[22] ^ st[17];
  endfunction

endpackage

// File: rtl/tpg_prbs.sv
module tpg_prbs
  import tpg_pkg::*;
#(
  parameter int SYM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  poly_e            poly,
  output logic [SYM_W-1:0] sym
);

  logic [PRBS_STATE_W-1:0] state_q;
  logic [PRBS_STATE_W-1:0] state_d;
  logic [PRBS_STATE_W-1:0] walk;
  logic [SYM_W-1:0]        bits;

  // Ten serial steps per symbol clock; first produced bit lands in bit 0.
  always_comb begin
    walk = state_q;
    bits = '0;
    for (int i = 0; i < SYM_W; i++) begin
      bits[i] = prbs_feedback(walk, poly);
      walk    = {walk[PRBS_STATE_W-2:0], bits[i]};
    end
    state_d = en ? walk : '1;
    sym     = en ? bits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '1;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/tpg_symstore.sv
module tpg_symstore #(
  parameter int SYM_W = 10,
  parameter int SLOTS = 8,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int CUST_W = SYM_W * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SYM_W-1:0]  wr_data,
  input  logic              cust_load,
  input  logic [CUST_W-1:0] cust_data,
  input  logic              bypass,
  output logic [SYM_W-1:0]  rd_sym,
  output logic [IDX_W-1:0]  rd_idx
);

  logic [SYM_W-1:0] slot_q [SLOTS];

  // The packed custom pattern is laid out so that slot k is simply
  // bits [10k+9:10k] of the little-endian byte string.
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [SYM_W-1:0] slot_d;
    logic             slot_ce;

    always_comb begin
      slot_ce = cust_load || (wr_en && (wr_idx == IDX_W'(k)));
      slot_d  = cust_load ? cust_data[k*SYM_W +: SYM_W] : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[k] <= '0;
      else if (slot_ce) slot_q[k] <= slot_d;
    end
  end

  logic             bypass_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             idx_ce;

  always_comb begin
    rd_idx = bypass_q ? idx_q : '0;
    idx_ce = bypass;
    idx_d  = (rd_idx == IDX_W'(SLOTS-1)) ? '0 : rd_idx + IDX_W'(1);
    rd_sym = slot_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bypass_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      bypass_q <= bypass;
      if (idx_ce) idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/tpg_lane_mux.sv
module tpg_lane_mux #(
  parameter int LANES = 4,
  parameter int SYM_W = 10,
  localparam int BUS_W = LANES * SYM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass,
  input  logic [LANES-1:0] lane_dbg,
  input  logic [SYM_W-1:0] dbg_sym,
  input  logic [SYM_W-1:0] prbs_sym,
  input  logic [BUS_W-1:0] link_in,
  output logic [BUS_W-1:0] lane_out
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SYM_W-1:0] lane_d;
    logic [SYM_W-1:0] lane_q;

    always_comb begin
      if (!bypass)          lane_d = link_in[l*SYM_W +: SYM_W];
      else if (lane_dbg[l]) lane_d = dbg_sym;
      else                  lane_d = prbs_sym;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign lane_out[l*SYM_W +: SYM_W] = lane_q;
  end

endmodule

// File: rtl/phy_tpg_top.sv
module phy_tpg_top
  import tpg_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SYM_W = 10,
  parameter int SLOTS = 8,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int CUST_W = SYM_W * SLOTS,
  localparam int BUS_W  = LANES * SYM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bypass,
  input  logic              cfg_prbs_en,
  input  logic              cfg_prbs_sel,
  input  logic [LANES-1:0]  cfg_lane_dbg,
  input  logic              sym_wr_en,
  input  logic [IDX_W-1:0]  sym_wr_idx,
  input  logic [SYM_W-1:0]  sym_wr_data,
  input  logic              cust_load,
  input  logic [CUST_W-1:0] cust_bytes,
  input  logic [BUS_W-1:0]  link_data_in,
  output logic [BUS_W-1:0]  lane_out
);

  logic [SYM_W-1:0] prbs_sym;
  logic [SYM_W-1:0] dbg_sym;
  logic [IDX_W-1:0] rd_idx;

  tpg_prbs #(.SYM_W(SYM_W)) u_prbs (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (cfg_prbs_en),
    .poly (poly_e'(cfg_prbs_sel)),
    .sym  (prbs_sym)
  );

  tpg_symstore #(.SYM_W(SYM_W), .SLOTS(SLOTS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (sym_wr_en),
    .wr_idx   (sym_wr_idx),
    .wr_data  (sym_wr_data),
    .cust_load(cust_load),
    .cust_data(cust_bytes),
    .bypass   (cfg_bypass),
    .rd_sym   (dbg_sym),
    .rd_idx   (rd_idx)
  );

  tpg_lane_mux #(.LANES(LANES), .SYM_W(SYM_W)) u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .bypass  (cfg_bypass),
    .lane_dbg(cfg_lane_dbg),
    .dbg_sym (dbg_sym),
    .prbs_sym(prbs_sym),
    .link_in (link_data_in),
    .lane_out(lane_out)
  );

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
  parameter int LANES = 4,
  parameter int SYM_W = 10,
  parameter int SLOTS = 8,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int BUS_W = LANES * SYM_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_bypass,
  input logic             cfg_prbs_en,
  input logic [LANES-1:0] cfg_lane_dbg,
  input logic [BUS_W-1:0] link_data_in,
  input logic [BUS_W-1:0] lane_out,
  input logic [IDX_W-1:0] rd_idx
);

  assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_bypass |=> lane_out == $past(link_data_in));

  assert_loop_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bypass && $past(cfg_bypass)) |->
      rd_idx == (($past(rd_idx) == IDX_W'(SLOTS-1)) ? '0 : $past(rd_idx) + IDX_W'(1)));

  assert_loop_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_bypass) |-> rd_idx == '0);

  assert_prbs_shared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bypass && !cfg_lane_dbg[0] && !cfg_lane_dbg[1]) |=>
      lane_out[SYM_W-1:0] == lane_out[2*SYM_W-1:SYM_W]);

  assert_loop_shared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bypass && cfg_lane_dbg[0] && cfg_lane_dbg[1]) |=>
      lane_out[SYM_W-1:0] == lane_out[2*SYM_W-1:SYM_W]);

  assert_prbs_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bypass && !cfg_prbs_en && !cfg_lane_dbg[0]) |=> lane_out[SYM_W-1:0] == '0);

endmodule

bind phy_tpg_top tpg_checker #(.LANES(LANES), .SYM_W(SYM_W), .SLOTS(SLOTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_bypass  (cfg_bypass),
  .cfg_prbs_en (cfg_prbs_en),
  .cfg_lane_dbg(cfg_lane_dbg),
  .link_data_in(link_data_in),
  .lane_out    (lane_out),
  .rd_idx      (rd_idx)
);

// File: tb/phy_tpg_top_bench.sv
`timescale 1ns/1ps
module phy_tpg_top_bench;

  localparam int LANES = 4;
  localparam int SYM_W = 10;
  localparam int SLOTS = 8;
  localparam int IDX_W = 3;
  localparam int CUST_W = SYM_W * SLOTS;
  localparam int BUS_W = LANES * SYM_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_bypass, cfg_prbs_en, cfg_prbs_sel;
  logic [LANES-1:0]  cfg_lane_dbg;
  logic              sym_wr_en;
  logic [IDX_W-1:0]  sym_wr_idx;
  logic [SYM_W-1:0]  sym_wr_data;
  logic              cust_load;
  logic [CUST_W-1:0] cust_bytes;
  logic [BUS_W-1:0]  link_data_in;
  logic [BUS_W-1:0]  lane_out;

  always #2.5 clk = ~clk;

  phy_tpg_top u_phy_tpg_top (
    .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_prbs_en(cfg_prbs_en),
    .cfg_prbs_sel(cfg_prbs_sel), .cfg_lane_dbg(cfg_lane_dbg), .sym_wr_en(sym_wr_en),
    .sym_wr_idx(sym_wr_idx), .sym_wr_data(sym_wr_data), .cust_load(cust_load),
    .cust_bytes(cust_bytes), .link_data_in(link_data_in), .lane_out(lane_out)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Reference model, built from the requirement text.
  logic [22:0]      m_st;
  logic [SYM_W-1:0] m_slot [SLOTS];
  logic             m_bq;
  int               m_idx;
  logic [SYM_W-1:0] hist [300];

  task automatic check(input string req, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic fb(input logic [22:0] s, input logic sel);
    return sel ? (s[22] ^ s[17]) : (s[6] ^ s[5]);
  endfunction

  // One clock: predict, apply, then compare at the following falling edge.
  task automatic tick(input string req);
    logic [BUS_W-1:0] exp;
    logic [SYM_W-1:0] psym;
    logic [22:0]      w;
    int               eff;
    w = m_st;
    for (int i = 0; i < SYM_W; i++) begin
      psym[i] = fb(w, cfg_prbs_sel);
      w = {w[21:0], psym[i]};
    end
    if (!cfg_prbs_en) psym = '0;
    eff = m_bq ? m_idx : 0;
    for (int l = 0; l < LANES; l++) begin
      if (!cfg_bypass)          exp[l*SYM_W +: SYM_W] = link_data_in[l*SYM_W +: SYM_W];
      else if (cfg_lane_dbg[l]) exp[l*SYM_W +: SYM_W] = m_slot[eff];
      else                      exp[l*SYM_W +: SYM_W] = psym;
    end
    if (cust_load) begin
      for (int g = 0; g < 2; g++) begin
        logic [7:0] b0, b1, b2, b3, b4;
        b0 = cust_bytes[(5*g+0)*8 +: 8];
        b1 = cust_bytes[(5*g+1)*8 +: 8];
        b2 = cust_bytes[(5*g+2)*8 +: 8];
        b3 = cust_bytes[(5*g+3)*8 +: 8];
        b4 = cust_bytes[(5*g+4)*8 +: 8];
        m_slot[4*g+0] = {b1[1:0], b0};
        m_slot[4*g+1] = {b2[3:0], b1[7:2]};
        m_slot[4*g+2] = {b3[5:0], b2[7:4]};
        m_slot[4*g+3] = {b4, b3[7:6]};
      end
    end else if (sym_wr_en) begin
      m_slot[sym_wr_idx] = sym_wr_data;
    end
    m_st = cfg_prbs_en ? w : '1;
    if (cfg_bypass) m_idx = (eff + 1) % SLOTS;
    m_bq = cfg_bypass;
    @(posedge clk);
    @(negedge clk);
    check(req, lane_out, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_bypass = 1'b0; cfg_prbs_en = 1'b0; cfg_prbs_sel = 1'b0;
    cfg_lane_dbg = '0; sym_wr_en = 1'b0; sym_wr_idx = '0; sym_wr_data = '0;
    cust_load = 1'b0; cust_bytes = '0; link_data_in = '0;
    m_st = '1; m_bq = 1'b0; m_idx = 0;
    for (int k = 0; k < SLOTS; k++) m_slot[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset output", lane_out, '0);
    rst_n = 1'b1;

    // R1: pass-through with several data patterns
    for (int p = 0; p < 8; p++) begin
      link_data_in = {BUS_W{1'b1}} ^ (BUS_W'(40'h9E3779B97F) << p) ^ BUS_W'(p * 1237);
      tick("R1 passthrough");
    end

    // R9: slots are zero after reset
    cfg_bypass = 1'b1; cfg_lane_dbg = '1;
    tick("R9 slots cleared");
    tick("R9 slots cleared");
    cfg_bypass = 1'b0;

    // R3: single-slot writes, done while passing data
    for (int k = 0; k < SLOTS; k++) begin
      sym_wr_en = 1'b1; sym_wr_idx = IDX_W'(k); sym_wr_data = SYM_W'(10'h3F0 ^ (k * 37));
      link_data_in = BUS_W'(k * 40'h0101010101);
      tick("R3 write during passthrough");
    end
    sym_wr_en = 1'b0;
    cfg_bypass = 1'b1;
    for (int c = 0; c < 2 * SLOTS; c++) tick("R3 R2 loop order");

    // R2: drop bypass mid-loop, rise again, loop restarts at slot 0
    cfg_bypass = 1'b0; tick("R2 drop");
    cfg_bypass = 1'b1;
    for (int c = 0; c < 3; c++) tick("R2 restart");
    cfg_bypass = 1'b0; tick("R2 drop");
    cfg_bypass = 1'b1;
    for (int c = 0; c < 10; c++) tick("R2 restart wrap");

    // R4: custom load has priority over a same-cycle single write
    cfg_bypass = 1'b0;
    cust_load = 1'b1;
    for (int b = 0; b < 10; b++) cust_bytes[b*8 +: 8] = 8'h5A ^ 8'(b * 29);
    sym_wr_en = 1'b1; sym_wr_idx = 3'd2; sym_wr_data = 10'h155;
    tick("R4 load");
    cust_load = 1'b0; sym_wr_en = 1'b0;
    cfg_bypass = 1'b1;
    for (int c = 0; c < SLOTS; c++) tick("R4 unpack priority");

    // R4: walking one over all pattern bits
    for (int bit_n = 0; bit_n < CUST_W; bit_n++) begin
      cfg_bypass = 1'b0; cust_load = 1'b1;
      cust_bytes = CUST_W'(1) << bit_n;
      tick("R4 walk load");
      cust_load = 1'b0; cfg_bypass = 1'b1;
      for (int c = 0; c < SLOTS; c++) tick("R4 walking one");
    end

    // R10: clock-like pattern
    cfg_bypass = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      sym_wr_en = 1'b1; sym_wr_idx = IDX_W'(k); sym_wr_data = 10'h2AA;
      tick("R10 fill");
    end
    sym_wr_en = 1'b0; cfg_bypass = 1'b1;
    for (int c = 0; c < 12; c++) begin
      tick("R10 constant");
      check("R10 constant 0x2AA", lane_out, {LANES{10'h2AA}});
    end

    // R5: short polynomial, first symbol and period
    cfg_bypass = 1'b0; cfg_prbs_en = 1'b0; tick("R8 reseed");
    cfg_prbs_sel = 1'b0; cfg_prbs_en = 1'b1; cfg_lane_dbg = '0; cfg_bypass = 1'b1;
    for (int c = 0; c < 300; c++) begin
      tick("R5 short sequence");
      hist[c] = lane_out[SYM_W-1:0];
    end
    check("R5 first symbol", BUS_W'(hist[0]), BUS_W'(10'h040));
    for (int c = 0; c < 150; c++)
      check("R5 period 127", BUS_W'(hist[c + 127]), BUS_W'(hist[c]));

    // R8: disabled generator outputs zero, then restarts from seed
    cfg_prbs_en = 1'b0;
    tick("R8 idle zero");
    check("R8 idle zero", lane_out, '0);
    cfg_prbs_en = 1'b1;
    tick("R8 restart");
    check("R8 reseeded first symbol", lane_out, {LANES{10'h040}});

    // R6: long polynomial
    cfg_prbs_en = 1'b0; tick("R8 reseed");
    cfg_prbs_sel = 1'b1; cfg_prbs_en = 1'b1;
    for (int c = 0; c < 300; c++) tick("R6 long sequence");

    // R7: mixed lane selects
    cfg_prbs_sel = 1'b0; cfg_lane_dbg = 4'b1010;
    for (int c = 0; c < 40; c++) begin
      tick("R7 mixed lanes");
      check("R7 prbs lanes equal", BUS_W'(lane_out[9:0]), BUS_W'(lane_out[29:20]));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule